// File: doc/BRIEF.md
# Interrupt Level Qualifier and Pender

This block turns three active-low interrupt priority lines into a held pending-interrupt indication. Every rising edge of the bus clock shifts the inverted lines into a short sample chain. A level counts as valid only when all taps of the chain hold the same value. A valid level that is greater than the three-bit mask from the status register is latched as pending, together with its level. The mask holds the highest level that is still ignored.

The pending state stays set after the requesting device withdraws its request. It is cleared only by an acknowledge input, which the processor raises while it runs the interrupt-acknowledge cycle, or by reset. If a higher valid level arrives while a request is pending, that level takes the place of the latched one. A lower level or an equal level leaves the latched level unchanged.

Top module: `irq_pender`

## Requirements
- R1: The requested level is the bitwise inverse of `ipl_n_i`. For example, `ipl_n_i` = 3'b010 requests level 5, and 3'b111 requests level 0.
- R2: A level that is seen at only one rising edge, and differs at the edges on either side, never makes a request pending.
- R3: A valid level becomes pending only when it is strictly greater than `mask_i`. A level equal to the mask, or below it, is ignored.
- R4: A valid level of 0 never sets `pend_o`, whatever the mask.
- R5: Once `pend_o` is set, it stays high with the same `pend_lvl_o` after the request is withdrawn, until acknowledge or reset.
- R6: A level seen at two consecutive rising edges k and k+1 is recognized, even if it changes right after edge k+1. `pend_o` is high after edge k+2.
- R7: While a request is pending, a valid level above `pend_lvl_o` replaces it. A valid level at or below `pend_lvl_o` leaves it unchanged.
- R8: `ack_i` high at a rising edge clears `pend_o` and sets `pend_lvl_o` to 0 after that edge. It wins over any request that would set or raise the pending state at the same edge.
- R9: Synchronous active-high `rst` clears the sample chain and the pending state. After reset, `pend_o` = 0 and `pend_lvl_o` = 0.
- R10: `pend_lvl_o` is 0 whenever `pend_o` is low, and it is non-zero whenever `pend_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. Inputs are sampled on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| ipl_n_i | input | 3 | Active-low interrupt priority lines. |
| mask_i | input | 3 | Highest ignored level, taken from the status register. |
| ack_i | input | 1 | Interrupt-acknowledge indication. Clears the pending state. |
| pend_o | output | 1 | A request is pending. |
| pend_lvl_o | output | 3 | Latched pending level. It is 0 when nothing is pending. |

## Verification
The bench builds the block with its default parameters: a three-bit level and a two-tap qualification chain. With a chain that short, single-cycle glitches, two-cycle pulses and the exact edge at which a two-cycle request turns pending can all be reached directly by stimulus. The three-bit width lets the bench sweep every relation between level and mask, from equal to the mask up to the top level 7 against mask 7. The behavioural model keeps the sample history in a queue sized by the same depth parameter, so it matches the design cycle by cycle.

// File: rtl/irq_pender_pkg.sv
package irq_pender_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic act;
        lvl_t lvl;
    } pend_t;

    localparam pend_t PEND_IDLE = '{act: 1'b0, lvl: '0};

    function automatic lvl_t lines_to_level(input lvl_t lines_n);
        return ~lines_n;
    endfunction

    // A candidate wins when it is non-zero, is above the mask, and is above any
    // level that is already pending.
    function automatic logic cand_wins(input lvl_t cand, input lvl_t mask,
                                       input pend_t cur);
        return (cand != '0) && (cand > mask) && (!cur.act || (cand > cur.lvl));
    endfunction

endpackage

// File: rtl/irq_lvl_sampler.sv
module irq_lvl_sampler
    import irq_pender_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t lines_n,
    output lvl_t cand,
    output logic stable
);

    lvl_t tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) tap[0] <= '0;
        else     tap[0] <= lines_to_level(lines_n);
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) tap[i] <= '0;
            else     tap[i] <= tap[i-1];
        end
    end

    always_comb begin
        stable = 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
            if (tap[i] != tap[0]) stable = 1'b0;
        end
    end

    assign cand = tap[0];

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pender_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ack,
    input  lvl_t  mask,
    input  lvl_t  cand,
    input  logic  stable,
    output pend_t st
);

    pend_t nxt;

    always_comb begin
        nxt = st;
        if (ack)
            nxt = PEND_IDLE;
        else if (stable && cand_wins(cand, mask, st))
            nxt = '{act: 1'b1, lvl: cand};
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PEND_IDLE;
        else     st <= nxt;
    end

endmodule

// File: rtl/irq_pender.sv
module irq_pender
    import irq_pender_pkg::*;
#(
    parameter int QUAL_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] ipl_n_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             ack_i,
    output logic             pend_o,
    output logic [LVL_W-1:0] pend_lvl_o
);

    localparam int TAPS = (QUAL_DEPTH < 2) ? 2 : QUAL_DEPTH;

    lvl_t  q_cand;
    logic  q_stable;
    pend_t p_st;

    irq_lvl_sampler #(.DEPTH(TAPS)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .lines_n(ipl_n_i),
        .cand   (q_cand),
        .stable (q_stable)
    );

    irq_pend_reg u_pend (
        .clk   (clk),
        .rst   (rst),
        .ack   (ack_i),
        .mask  (mask_i),
        .cand  (q_cand),
        .stable(q_stable),
        .st    (p_st)
    );

    assign pend_o     = p_st.act;
    assign pend_lvl_o = p_st.lvl;

endmodule

// File: rtl/irq_pender_chk.sv
module irq_pender_chk
    import irq_pender_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ack_i,
    input lvl_t mask_i,
    input logic pend_o,
    input lvl_t pend_lvl_o,
    input logic q_stable
);

    assert_stable_before_pend_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(q_stable));

    assert_above_mask_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> (pend_lvl_o > $past(mask_i)));

    assert_hold_or_raise_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !ack_i) |=> (pend_o && (pend_lvl_o >= $past(pend_lvl_o))));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (!pend_o && (pend_lvl_o == '0)));

    assert_lvl_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        pend_o |-> (pend_lvl_o != '0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !pend_o |-> (pend_lvl_o == '0));

endmodule

bind irq_pender irq_pender_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .ack_i     (ack_i),
    .mask_i    (mask_i),
    .pend_o    (pend_o),
    .pend_lvl_o(pend_lvl_o),
    .q_stable  (q_stable)
);

// File: tb/irq_pender_tb_top.sv
module irq_pender_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ipl_n = 3'b111;
    logic [2:0] mask = 3'd0;
    logic       ack = 1'b0;
    logic       pend;
    logic [2:0] plvl;

    int total = 0;
    int bad = 0;
    string phase = "R9";

    int hist[$];
    int m_pend = 0;
    int m_lvl = 0;
    int req;
    int cand;
    bit ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pender #(.QUAL_DEPTH(QD)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ipl_n_i   (ipl_n),
        .mask_i    (mask),
        .ack_i     (ack),
        .pend_o    (pend),
        .pend_lvl_o(plvl)
    );

    // Behavioural reference model: the sample history lives in a queue.
    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_pend = 0;
            m_lvl = 0;
        end else begin
            ok = (hist.size() >= QD);
            if (ok) begin
                for (int i = 1; i < QD; i++)
                    if (hist[hist.size()-1-i] != hist[hist.size()-1]) ok = 0;
            end
            cand = (hist.size() > 0) ? hist[hist.size()-1] : 0;
            if (ack) begin
                m_pend = 0;
                m_lvl = 0;
            end else if (ok && cand != 0 && cand > int'(mask)
                         && (m_pend == 0 || cand > m_lvl)) begin
                m_pend = 1;
                m_lvl = cand;
            end
            req = 7 - int'(ipl_n);
            hist.push_back(req);
            if (hist.size() > QD) void'(hist.pop_front());
        end
    end

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (int'(pend) != m_pend || int'(plvl) != m_lvl) begin
                bad++;
                $display("FAIL %s model: act pend=%0d lvl=%0d exp pend=%0d lvl=%0d",
                         phase, pend, plvl, m_pend, m_lvl);
            end
        end
    end

    task automatic chk(input string tag, input int act_p, input int act_l,
                       input int exp_p, input int exp_l);
        total++;
        if (act_p != exp_p || act_l != exp_l) begin
            bad++;
            $display("FAIL %s: act pend=%0d lvl=%0d exp pend=%0d lvl=%0d",
                     tag, act_p, act_l, exp_p, exp_l);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic level(input int l);
        ipl_n = ~3'(l);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: act running exp finished");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R9 reset", pend, plvl, 0, 0);
        rst = 1'b0;
        cyc(1);
        chk("R9 after release", pend, plvl, 0, 0);

        phase = "R4";
        level(0);
        cyc(5);
        chk("R4 zero level", pend, plvl, 0, 0);

        phase = "R2";
        level(3);
        cyc(1);
        level(0);
        cyc(4);
        chk("R2 glitch ignored", pend, plvl, 0, 0);

        phase = "R6";
        ipl_n = 3'b010;
        cyc(2);
        level(0);
        cyc(1);
        chk("R6 two-clock pulse", pend, plvl, 1, 5);
        chk("R1 inverted level", int'(plvl), 0, 5, 0);

        phase = "R5";
        cyc(10);
        chk("R5 held after withdraw", pend, plvl, 1, 5);

        phase = "R7";
        level(3);
        cyc(4);
        chk("R7 lower ignored", pend, plvl, 1, 5);
        level(5);
        cyc(4);
        chk("R7 equal ignored", pend, plvl, 1, 5);
        level(7);
        cyc(4);
        chk("R7 higher replaces", pend, plvl, 1, 7);

        phase = "R8";
        level(0);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        chk("R8 ack clears", pend, plvl, 0, 0);
        chk("R10 idle level zero", int'(plvl), 0, 0, 0);
        level(6);
        ack = 1'b1;
        cyc(4);
        chk("R8 ack beats request", pend, plvl, 0, 0);
        ack = 1'b0;
        cyc(1);
        chk("R8 request after ack", pend, plvl, 1, 6);
        level(0);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        cyc(2);
        chk("R8 clear again", pend, plvl, 0, 0);

        phase = "R3";
        mask = 3'd4;
        level(4);
        cyc(4);
        chk("R3 equal to mask", pend, plvl, 0, 0);
        level(2);
        cyc(4);
        chk("R3 below mask", pend, plvl, 0, 0);
        level(5);
        cyc(3);
        chk("R3 above mask", pend, plvl, 1, 5);
        level(0);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        mask = 3'd7;
        level(7);
        cyc(4);
        chk("R3 mask 7 blocks all", pend, plvl, 0, 0);
        mask = 3'd0;
        cyc(2);
        chk("R3 mask lowered", pend, plvl, 1, 7);

        phase = "R9";
        rst = 1'b1;
        cyc(1);
        chk("R9 reset clears pend", pend, plvl, 0, 0);
        level(0);
        cyc(1);
        rst = 1'b0;
        cyc(3);
        chk("R9 idle after reset", pend, plvl, 0, 0);

        finish_run();
    end

endmodule